// File: doc/BRIEF.md
# Pixel Clock Divider Search Engine

This block turns a requested pixel clock, given in whole kHz, into divider settings for a clock synthesizer. The synthesizer produces `ref * (N+1) / (M+1)` at its oscillator and divides that by `P+1` at its output. The engine first raises requests that are too low. It then picks a post divider that puts the oscillator target at or above 50000 kHz. Next it scans every allowed (M, N) pair and keeps the pair whose oscillator frequency lies closest to the target. Last, it derives a loop filter range from the oscillator frequency that was achieved. It returns three packed register bytes together with the achieved oscillator and output frequencies.

Requests enter on a valid/ready stream. The engine takes one request at a time. `in_ready` is high only while the engine is idle, so a request offered during a search waits upstream and is not lost. The result leaves on a second valid/ready stream. The result is held unchanged until the consumer raises `out_ready`, and the engine cannot accept a new request until the result has been taken. All frequencies inside the engine are fixed point with 2 fractional bits (quarter-kHz units). Divisions during the search are replaced by exact cross-multiplied comparisons. A single multi-cycle restoring divider computes the achieved frequency once the best pair is known.

Top module: `pll_search_engine`

## Requirements
- R1: A request below 6250 kHz (including 0) is treated as exactly 6250 kHz, both in the search and as the starting best error.
- R2: The post divider P starts at 0. While P <= 7 and the oscillator target is below 50000 kHz, P becomes 2P+1 and the target doubles. P is therefore always 0, 1, 3 or 7 (for example 30000 kHz gives P=1, 12500 kHz gives P=3, 12499 kHz gives P=7).
- R3: The achieved oscillator frequency `out_vco_q` is floor(4*ref*(N+1)/(M+1)) in quarter-kHz. `out_freq_q` is `out_vco_q` divided by P+1, rounded down.
- R4: M is scanned ascending in the outer loop and N ascending in the inner loop. A candidate replaces the best only when its exact error |ref*(N+1)/(M+1) - target| is strictly smaller. The starting best error is the clamped request and the starting best pair is the lowest (M, N), so on a tie the first minimum wins.
- R5: `in_mode` picks the limits. Mode 0 uses M 1..31, N 100..127 and the low reference of 57273 quarter-kHz. Modes 1 and 3 use M 1..31, N 7..127 and the high reference of 108202 quarter-kHz. Mode 2 uses M 1..6, N 7..127 with the high reference when `in_ref_alt`=0 and the low reference when it is 1.
- R6: The filter range S is 0 below 100000 kHz, 1 in [100000, 140000), 2 in [140000, 180000) and 3 at 180000 kHz and above, judged on the achieved oscillator frequency.
- R7: `out_m_byte` holds M in bits 4:0 and `out_n_byte` holds N in bits 6:0. `out_ps_byte` holds P in bits 2:0 and S in bits 4:3. All other bits are zero.
- R8: A request is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low from the cycle after acceptance until the result has been taken, and a request offered during that time has no effect on the result in progress.
- R9: Once `out_valid` rises, it stays high and all result outputs stay stable until a clock edge with `out_ready` high. After that edge `out_valid` is low.
- R10: After reset `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Engine idle, request can be taken |
| in_freq_khz | input | 20 | Requested output frequency in kHz |
| in_mode | input | 2 | Divider limit and reference selection |
| in_ref_alt | input | 1 | Reference choice in mode 2 |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_m_byte | output | 8 | Packed input divider byte |
| out_n_byte | output | 8 | Packed feedback divider byte |
| out_ps_byte | output | 8 | Packed post divider and filter range byte |
| out_vco_q | output | 24 | Achieved oscillator frequency, quarter-kHz |
| out_freq_q | output | 24 | Achieved output frequency, quarter-kHz |

## Verification
The embedded properties check several things on every cycle: the handshake rules (no acceptance while a result waits, and results frozen under back-pressure), that only legal post-divider values appear, that the scan counters stay inside the limits latched at start, that the best error never grows during a scan, and that the divider remainder stays below the divisor. Only the bench scenarios can show that the chosen pair is the true first minimum for a given request. The same holds for the clamp of low requests, for the reference and limit selection in each mode, for tie handling, and for the filter band boundaries. The bench compares these against an exact integer model over a sweep of requests.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;
  localparam int FREQ_W      = 20;
  localparam int Q_W         = FREQ_W + 2;
  localparam int M_W         = 5;
  localparam int N_W         = 7;
  localparam int MP_W        = M_W + 1;
  localparam int POST_W      = 3;
  localparam int POST_STEPS  = 3;
  localparam int REF_W       = 17;
  localparam int PROD_W      = Q_W + MP_W;
  localparam int CMP_W       = PROD_W + MP_W;
  localparam int VCO_W       = 24;
  localparam int BYTE_W      = 8;

  localparam int MIN_VCO_KHZ = 50000;
  localparam int CLAMP_KHZ   = MIN_VCO_KHZ / 8;

  localparam int REF_LO_Q    = 57273;
  localparam int REF_HI_Q    = 108202;

  localparam int M_LO        = 1;
  localparam int M_HI_WIDE   = 31;
  localparam int M_HI_NARROW = 6;
  localparam int N_LO_FINE   = 100;
  localparam int N_LO        = 7;
  localparam int N_HI        = 127;

  localparam int BAND1_Q     = 100000 * 4;
  localparam int BAND2_Q     = 140000 * 4;
  localparam int BAND3_Q     = 180000 * 4;

  typedef struct packed {
    logic [M_W-1:0]   m_min;
    logic [M_W-1:0]   m_max;
    logic [N_W-1:0]   n_min;
    logic [N_W-1:0]   n_max;
    logic [REF_W-1:0] ref_q;
  } limits_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_DIV, ST_HOLD} eng_state_t;

  function automatic limits_t mode_limits(input logic [1:0] mode, input logic alt);
    limits_t l;
    l.m_min = M_W'(M_LO);
    l.m_max = M_W'(M_HI_WIDE);
    l.n_min = N_W'(N_LO);
    l.n_max = N_W'(N_HI);
    l.ref_q = REF_W'(REF_HI_Q);
    case (mode)
      2'd0: begin
        l.n_min = N_W'(N_LO_FINE);
        l.ref_q = REF_W'(REF_LO_Q);
      end
      2'd2: begin
        l.m_max = M_W'(M_HI_NARROW);
        l.ref_q = alt ? REF_W'(REF_LO_Q) : REF_W'(REF_HI_Q);
      end
      default: ;
    endcase
    return l;
  endfunction
endpackage

// File: rtl/pll_post_div.sv
module pll_post_div
  import pll_search_pkg::*;
(
  input  logic [FREQ_W-1:0] freq_khz,
  output logic [Q_W-1:0]    init_err_q,
  output logic [Q_W-1:0]    target_q,
  output logic [POST_W-1:0] post_div
);
  logic [FREQ_W-1:0] clamped;
  logic [FREQ_W-1:0] tgt;
  logic [POST_W-1:0] p;

  always_comb begin
    clamped = (freq_khz < FREQ_W'(CLAMP_KHZ)) ? FREQ_W'(CLAMP_KHZ) : freq_khz;
    tgt = clamped;
    p   = '0;
    for (int i = 0; i < POST_STEPS; i++) begin
      if (tgt < FREQ_W'(MIN_VCO_KHZ)) begin
        p   = {p[POST_W-2:0], 1'b1};
        tgt = {tgt[FREQ_W-2:0], 1'b0};
      end
    end
  end

  assign init_err_q = {clamped, 2'b00};
  assign target_q   = {tgt, 2'b00};
  assign post_div   = p;
endmodule

// File: rtl/pll_pair_scan.sv
module pll_pair_scan
  import pll_search_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  limits_t        lim,
  input  logic [Q_W-1:0] target_q,
  input  logic [Q_W-1:0] init_err_q,
  output logic           busy,
  output logic           done,
  output logic [M_W-1:0] best_m,
  output logic [N_W-1:0] best_n
);
  limits_t             lim_r;
  logic [Q_W-1:0]      tgt_r;
  logic [M_W-1:0]      m_c;
  logic [N_W-1:0]      n_c;
  logic [PROD_W-1:0]   bnum;
  logic [MP_W-1:0]     bden;

  logic [PROD_W-1:0]   a_ref, a_tgt, diff;
  logic [CMP_W-1:0]    lhs, rhs;
  logic                better, last;

  assign a_ref  = PROD_W'(lim_r.ref_q) * (PROD_W'(n_c) + PROD_W'(1));
  assign a_tgt  = PROD_W'(tgt_r) * (PROD_W'(m_c) + PROD_W'(1));
  assign diff   = (a_ref >= a_tgt) ? (a_ref - a_tgt) : (a_tgt - a_ref);
  assign lhs    = CMP_W'(diff) * CMP_W'(bden);
  assign rhs    = CMP_W'(bnum) * (CMP_W'(m_c) + CMP_W'(1));
  assign better = lhs < rhs;
  assign last   = (m_c == lim_r.m_max) && (n_c == lim_r.n_max);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_r  <= '0;
      tgt_r  <= '0;
      m_c    <= '0;
      n_c    <= '0;
      best_m <= '0;
      best_n <= '0;
      bnum   <= '0;
      bden   <= MP_W'(1);
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        lim_r  <= lim;
        tgt_r  <= target_q;
        m_c    <= lim.m_min;
        n_c    <= lim.n_min;
        best_m <= lim.m_min;
        best_n <= lim.n_min;
        bnum   <= PROD_W'(init_err_q);
        bden   <= MP_W'(1);
        busy   <= 1'b1;
      end else if (busy) begin
        if (better) begin
          best_m <= m_c;
          best_n <= n_c;
          bnum   <= diff;
          bden   <= MP_W'(m_c) + MP_W'(1);
        end
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else if (n_c == lim_r.n_max) begin
          n_c <= lim_r.n_min;
          m_c <= m_c + M_W'(1);
        end else begin
          n_c <= n_c + N_W'(1);
        end
      end
    end
  end

  // R5: scan counters never leave the limits latched at start
  p_scan_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (m_c >= lim_r.m_min) && (m_c <= lim_r.m_max) &&
             (n_c >= lim_r.n_min) && (n_c <= lim_r.n_max));

  // R4: the best error recorded never grows while scanning
  p_best_monotone_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |->
      (CMP_W'(bnum) * CMP_W'($past(bden)) <= CMP_W'($past(bnum)) * CMP_W'(bden)));
endmodule

// File: rtl/pll_restoring_div.sv
module pll_restoring_div #(
  parameter int DVD_W = 28,
  parameter int DVS_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [DVD_W-1:0] quotient
);
  localparam int CNT_W = $clog2(DVD_W + 1);

  logic [DVD_W-1:0] dvd_r;
  logic [DVS_W-1:0] dvs_r;
  logic [DVS_W-1:0] rem;
  logic [CNT_W-1:0] cnt;
  logic [DVS_W:0]   rem_sh;
  logic             step_bit;
  logic [DVS_W-1:0] step_rem;

  assign rem_sh   = {rem, dvd_r[DVD_W-1]};
  assign step_bit = rem_sh >= {1'b0, dvs_r};
  assign step_rem = step_bit ? DVS_W'(rem_sh - {1'b0, dvs_r}) : rem_sh[DVS_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_r    <= '0;
      dvs_r    <= '0;
      rem      <= '0;
      cnt      <= '0;
      quotient <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        dvd_r    <= dividend;
        dvs_r    <= divisor;
        rem      <= '0;
        cnt      <= '0;
        quotient <= '0;
        busy     <= 1'b1;
      end else if (busy) begin
        rem      <= step_rem;
        quotient <= {quotient[DVD_W-2:0], step_bit};
        dvd_r    <= {dvd_r[DVD_W-2:0], 1'b0};
        cnt      <= cnt + CNT_W'(1);
        if (cnt == CNT_W'(DVD_W - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R3: the partial remainder always stays below the divisor
  p_rem_below_divisor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rem < dvs_r));

  // R3: the division never runs longer than one step per dividend bit
  p_div_length_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < CNT_W'(DVD_W)));
endmodule

// File: rtl/pll_search_engine.sv
module pll_search_engine
  import pll_search_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FREQ_W-1:0] in_freq_khz,
  input  logic [1:0]        in_mode,
  input  logic              in_ref_alt,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_m_byte,
  output logic [BYTE_W-1:0] out_n_byte,
  output logic [BYTE_W-1:0] out_ps_byte,
  output logic [VCO_W-1:0]  out_vco_q,
  output logic [VCO_W-1:0]  out_freq_q
);
  eng_state_t        state;
  logic              accept;
  limits_t           lim_in;
  logic [Q_W-1:0]    init_err_q, target_q;
  logic [POST_W-1:0] post_div;

  logic [REF_W-1:0]  ref_r;
  logic [POST_W-1:0] p_r;
  logic [M_W-1:0]    m_r;
  logic [N_W-1:0]    n_r;
  logic [VCO_W-1:0]  vco_r;

  logic              scan_busy, scan_done;
  logic [M_W-1:0]    scan_m;
  logic [N_W-1:0]    scan_n;
  logic              div_busy, div_done;
  logic [PROD_W-1:0] div_dvd, div_quo;
  logic [MP_W-1:0]   div_dvs;

  logic [1:0]        s_sel;
  logic [1:0]        shift;

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_HOLD);
  assign accept    = in_valid && in_ready;
  assign lim_in    = mode_limits(in_mode, in_ref_alt);

  pll_post_div u_post (
    .freq_khz   (in_freq_khz),
    .init_err_q (init_err_q),
    .target_q   (target_q),
    .post_div   (post_div)
  );

  pll_pair_scan u_scan (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .lim        (lim_in),
    .target_q   (target_q),
    .init_err_q (init_err_q),
    .busy       (scan_busy),
    .done       (scan_done),
    .best_m     (scan_m),
    .best_n     (scan_n)
  );

  assign div_dvd = PROD_W'(ref_r) * (PROD_W'(scan_n) + PROD_W'(1));
  assign div_dvs = MP_W'(scan_m) + MP_W'(1);

  pll_restoring_div #(.DVD_W(PROD_W), .DVS_W(MP_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (scan_done),
    .dividend (div_dvd),
    .divisor  (div_dvs),
    .busy     (div_busy),
    .done     (div_done),
    .quotient (div_quo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ref_r <= '0;
      p_r   <= '0;
      m_r   <= '0;
      n_r   <= '0;
      vco_r <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          ref_r <= lim_in.ref_q;
          p_r   <= post_div;
          state <= ST_SCAN;
        end
        ST_SCAN: if (scan_done) begin
          m_r   <= scan_m;
          n_r   <= scan_n;
          state <= ST_DIV;
        end
        ST_DIV: if (div_done) begin
          vco_r <= div_quo[VCO_W-1:0];
          state <= ST_HOLD;
        end
        default: if (out_ready) state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    if (vco_r >= VCO_W'(BAND3_Q))      s_sel = 2'd3;
    else if (vco_r >= VCO_W'(BAND2_Q)) s_sel = 2'd2;
    else if (vco_r >= VCO_W'(BAND1_Q)) s_sel = 2'd1;
    else                               s_sel = 2'd0;
    case (p_r)
      3'd1:    shift = 2'd1;
      3'd3:    shift = 2'd2;
      3'd7:    shift = 2'd3;
      default: shift = 2'd0;
    endcase
  end

  assign out_m_byte  = {{(BYTE_W-M_W){1'b0}}, m_r};
  assign out_n_byte  = {{(BYTE_W-N_W){1'b0}}, n_r};
  assign out_ps_byte = {3'b000, s_sel, p_r};
  assign out_vco_q   = vco_r;
  assign out_freq_q  = vco_r >> shift;

  // R8: no new request is taken while a result waits
  p_no_accept_in_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R8: acceptance closes the input until the result is taken
  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R9: back-pressure freezes the result
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_m_byte) &&
      $stable(out_n_byte) && $stable(out_ps_byte) && $stable(out_vco_q)));

  // R2: only post divider values 0, 1, 3, 7 are ever presented
  p_post_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot({1'b0, out_ps_byte[2:0]} + 4'd1));

  // R3: output frequency never exceeds the oscillator frequency
  p_freq_below_vco_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_freq_q <= out_vco_q));

  // R5: scan and divider are never active at once
  p_single_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(scan_busy && div_busy));
endmodule

// File: tb/test_pll_search_engine.sv
`timescale 1ns/1ps
module test_pll_search_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [19:0] in_freq_khz = '0;
  logic [1:0]  in_mode = '0;
  logic        in_ref_alt = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_m_byte, out_n_byte, out_ps_byte;
  logic [23:0] out_vco_q, out_freq_q;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pll_search_engine i_pll_search_engine (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_freq_khz(in_freq_khz),
    .in_mode(in_mode), .in_ref_alt(in_ref_alt),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_m_byte(out_m_byte), .out_n_byte(out_n_byte), .out_ps_byte(out_ps_byte),
    .out_vco_q(out_vco_q), .out_freq_q(out_freq_q)
  );

  typedef struct packed {
    logic [19:0] f;
    logic [1:0]  mode;
    logic        alt;
    logic [2:0]  p;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [0:NV-1] = '{
    '{20'd25175,  2'd0, 1'b0, 3'd1},
    '{20'd31500,  2'd0, 1'b0, 3'd1},
    '{20'd40000,  2'd1, 1'b0, 3'd1},
    '{20'd65000,  2'd1, 1'b0, 3'd0},
    '{20'd108000, 2'd1, 1'b0, 3'd0},
    '{20'd135000, 2'd1, 1'b0, 3'd0},
    '{20'd157500, 2'd2, 1'b0, 3'd0},
    '{20'd200000, 2'd2, 1'b1, 3'd0},
    '{20'd250000, 2'd0, 1'b0, 3'd0},
    '{20'd12500,  2'd1, 1'b0, 3'd3},
    '{20'd7000,   2'd2, 1'b0, 3'd7},
    '{20'd300000, 2'd1, 1'b0, 3'd0},
    '{20'd49999,  2'd3, 1'b0, 3'd1},
    '{20'd24999,  2'd0, 1'b0, 3'd3}
  };

  int     em, en, ep, es;
  longint evco, efq;

  task automatic model(input int f, input int mode, input int alt);
    longint fc, t, refq, bnum, bden, diff, a, b;
    int p, mlo, mhi, nlo, nhi;
    fc = (f < 6250) ? 6250 : f;
    t = fc; p = 0;
    while (p <= 7 && t < 50000) begin p = p * 2 + 1; t = t * 2; end
    mlo = 1; mhi = 31; nlo = 7; nhi = 127; refq = 108202;
    if (mode == 0) begin nlo = 100; refq = 57273; end
    else if (mode == 2) begin mhi = 6; refq = (alt != 0) ? 57273 : 108202; end
    bnum = fc * 4; bden = 1; em = mlo; en = nlo;
    for (int m = mlo; m <= mhi; m++) begin
      for (int n = nlo; n <= nhi; n++) begin
        a = refq * (n + 1);
        b = t * 4 * (m + 1);
        diff = (a > b) ? a - b : b - a;
        if (diff * bden < bnum * (m + 1)) begin
          bnum = diff; bden = m + 1; em = m; en = n;
        end
      end
    end
    evco = refq * (en + 1) / (em + 1);
    if (evco >= 720000) es = 3;
    else if (evco >= 560000) es = 2;
    else if (evco >= 400000) es = 1;
    else es = 0;
    ep = p;
    efq = evco / (p + 1);
  endtask

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic request(input int f, input int mode, input int alt);
    @(negedge clk);
    in_freq_khz = 20'(f); in_mode = 2'(mode); in_ref_alt = alt[0]; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    while (!out_valid) @(negedge clk);
  endtask

  task automatic release_out();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic compare_all(input string tag);
    check({tag, " R4 R5 R7 m byte"}, out_m_byte, em);
    check({tag, " R4 R5 R7 n byte"}, out_n_byte, en);
    check({tag, " R2 R6 R7 ps byte"}, out_ps_byte, longint'(es * 8 + ep));
    check({tag, " R3 vco"}, out_vco_q, evco);
    check({tag, " R3 out freq"}, out_freq_q, efq);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R8: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0]  sm, sn, sps;
    logic [23:0] sv;
    int stable_ok, busy_ok;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 in_ready after reset", in_ready, 1);
    check("R10 out_valid after reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 in_ready idle", in_ready, 1);

    // table sweep against the reference model
    for (int i = 0; i < NV; i++) begin
      model(int'(VEC[i].f), int'(VEC[i].mode), int'(VEC[i].alt));
      request(int'(VEC[i].f), int'(VEC[i].mode), int'(VEC[i].alt));
      check("R2 table post divider", out_ps_byte[2:0], VEC[i].p);
      compare_all("sweep");
      // R6: band explicitly
      check("R6 filter range", out_ps_byte[4:3], es);
      release_out();
    end

    // R1: low requests clamp to 6250 kHz
    request(6250, 0, 0);
    sm = out_m_byte; sn = out_n_byte; sps = out_ps_byte; sv = out_vco_q;
    release_out();
    request(1000, 0, 0);
    check("R1 clamp m", out_m_byte, sm);
    check("R1 clamp n", out_n_byte, sn);
    check("R1 clamp ps", out_ps_byte, sps);
    check("R1 clamp vco", out_vco_q, sv);
    check("R1 clamp P=7", out_ps_byte[2:0], 7);
    release_out();
    model(0, 1, 0);
    request(0, 1, 0);
    compare_all("R1 zero");
    release_out();
    model(12499, 2, 1);
    request(12499, 2, 1);
    check("R2 12499 gives P=7", out_ps_byte[2:0], 7);
    compare_all("R2 edge");
    release_out();

    // R4: exact tie, ratio 4 reached first at M=1 N=7
    request(108202, 1, 0);
    check("R4 tie first m", out_m_byte, 1);
    check("R4 tie first n", out_n_byte, 7);
    check("R3 tie vco", out_vco_q, 432808);
    release_out();

    // R8: requests offered while busy are ignored
    model(30000, 0, 0);
    @(negedge clk);
    in_freq_khz = 20'd30000; in_mode = 2'd0; in_ref_alt = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_freq_khz = 20'd200000; in_mode = 2'd1;
    busy_ok = 1;
    for (int k = 0; k < 20; k++) begin
      if (in_ready) busy_ok = 0;
      @(negedge clk);
    end
    check("R8 in_ready low while busy", busy_ok, 1);
    in_valid = 1'b0;
    while (!out_valid) @(negedge clk);
    compare_all("R8 ignored");
    check("R8 in_ready low with result", in_ready, 0);
    release_out();
    check("R8 in_ready after take", in_ready, 1);

    // R9: back-pressure hold
    model(65000, 2, 0);
    request(65000, 2, 0);
    sm = out_m_byte; sn = out_n_byte; sps = out_ps_byte; sv = out_vco_q;
    stable_ok = 1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (!out_valid || out_m_byte != sm || out_n_byte != sn ||
          out_ps_byte != sps || out_vco_q != sv) stable_ok = 0;
    end
    check("R9 result held under back-pressure", stable_ok, 1);
    compare_all("R9 held");
    release_out();
    check("R9 out_valid drops after take", out_valid, 0);

    summary();
    $finish;
  end
endmodule